// File: doc/BRIEF.md
# Debug Clock Freeze and Single-Step Controller

This block sits between a system clock and a processor core under test and produces a synchronous clock enable for that core. While the core runs, every enabled cycle advances a 32-bit cycle counter, so that the state of the silicon can be lined up with a simulation of the same program cycle by cycle. The core can be frozen in two ways: an internal stop fires when the counter reaches a programmed value with the stop enabled, and an external stop request may arrive at any time with no relation to the system clock.

While frozen, a single-step request lets exactly one enabled core cycle through. A resume request returns the core to free running. The step request may come from an operator or from other debug logic, so it is edge-detected and a held request yields only one pulse.

The controller is one state machine with four states. RUN is free running. HALT is frozen. STEP is the single enabled cycle of a step. RELEASE is the first enabled cycle after a resume. The transitions are: RUN to HALT on a counter match or a synchronized external stop; HALT to RELEASE on resume; HALT to STEP on a new step request; STEP back to HALT; RELEASE on to RUN.

Top module: `dbg_clock_freeze`

## Requirements
- R1: After reset the state is RUN: `frozen` is 0, `cycle_cnt` is 0 and `core_clk_en` is 1, unless an internal stop matches at once.
- R2: When `stop_at_en` is 1 and `cycle_cnt` equals `stop_at` in RUN, `core_clk_en` is 0 in that same cycle and `frozen` is 1 from the next cycle on. The count then equals `stop_at` exactly, and `stop_at = 0` freezes straight after reset.
- R3: `cycle_cnt` rises by one on every clock edge at which `core_clk_en` was 1. It holds its value at every other edge.
- R4: `ext_stop` passes through a two-stage synchronizer. When it is raised in RUN, `core_clk_en` falls after the second clock edge and `frozen` rises after the third. The count advances by 2 after the raise.
- R5: A rising edge of `step_req` in HALT gives exactly one cycle with `core_clk_en` equal to 1 and then returns to HALT. Holding `step_req` high gives no further pulses.
- R6: A rising edge of `step_req` has no effect in RUN: the core does not freeze and counting is not disturbed.
- R7: `resume` in HALT gives one enabled cycle that ignores a still-matching stop value. Running then continues.
- R8: If `resume` and a new `step_req` edge arrive in the same HALT cycle, resume wins and the core keeps running.
- R9: When `stop_at_en` is 0, no internal stop happens, whatever the value of `stop_at`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_stop | input | 1 | Asynchronous external freeze request |
| step_req | input | 1 | Single-step request, acted on at its rising edge |
| resume | input | 1 | Leave the frozen state |
| stop_at | input | 32 | Programmed stop cycle count |
| stop_at_en | input | 1 | Enables the internal stop at `stop_at` |
| core_clk_en | output | 1 | Synchronous clock enable for the core |
| cycle_cnt | output | 32 | Number of enabled core cycles since reset |
| frozen | output | 1 | High while in HALT |

## Verification
Two of the block's functions can fall in the same frozen cycle: a resume request and a fresh single-step edge. The bench raises both on the same falling edge. It then judges the outcome by whether the core keeps counting without refreezing, which is the resume behaviour, or drops back to HALT after one cycle, which is the step behaviour. A second overlap, a resume while the stop value still matches the count, is provoked by stopping at a programmed count and resuming. The check is that the release cycle moves the count past the match.

// File: rtl/dbgclk_pkg.sv
package dbgclk_pkg;
    localparam int CNT_W = 32;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALT    = 2'd1,
        ST_STEP    = 2'd2,
        ST_RELEASE = 2'd3
    } gate_state_t;
endpackage

// File: rtl/dbgclk_sync.sv
module dbgclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dbgclk_counter.sv
module dbgclk_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/dbgclk_fsm.sv
module dbgclk_fsm
    import dbgclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_stop_s,
    input  logic step_req,
    input  logic resume,
    input  logic match,
    output logic core_clk_en,
    output logic frozen
);
    gate_state_t state_q, state_d;
    logic        step_q;
    logic        step_edge;

    assign step_edge = step_req && !step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            step_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_req;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (match || ext_stop_s) state_d = ST_HALT;
            ST_HALT: begin
                if (resume)         state_d = ST_RELEASE;
                else if (step_edge) state_d = ST_STEP;
            end
            ST_STEP:    state_d = ST_HALT;
            ST_RELEASE: state_d = ST_RUN;
            default:    state_d = ST_HALT;
        endcase
    end

    always_comb begin
        core_clk_en = 1'b0;
        frozen      = 1'b0;
        unique case (state_q)
            ST_RUN:     core_clk_en = !match && !ext_stop_s;
            ST_HALT:    frozen = 1'b1;
            ST_STEP:    core_clk_en = 1'b1;
            ST_RELEASE: core_clk_en = 1'b1;
            default:    frozen = 1'b1;
        endcase
    end

    // R2
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && match) |-> (!core_clk_en ##1 frozen));
    // R5
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (frozen && !core_clk_en));
    // R6
    run_step_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !match && !ext_stop_s) |=> !frozen);
    // R7
    release_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && resume) |=> (core_clk_en && !frozen));
endmodule

// File: rtl/dbg_clock_freeze.sv
module dbg_clock_freeze
    import dbgclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_stop,
    input  logic             step_req,
    input  logic             resume,
    input  logic [CNT_W-1:0] stop_at,
    input  logic             stop_at_en,
    output logic             core_clk_en,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic             frozen
);
    logic ext_stop_s;
    logic match;

    dbgclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_stop),
        .dout  (ext_stop_s)
    );

    assign match = stop_at_en && (cycle_cnt == stop_at);

    dbgclk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_stop_s  (ext_stop_s),
        .step_req    (step_req),
        .resume      (resume),
        .match       (match),
        .core_clk_en (core_clk_en),
        .frozen      (frozen)
    );

    dbgclk_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (core_clk_en),
        .count (cycle_cnt)
    );

    // R9
    no_stop_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_at_en && !ext_stop_s && !frozen) |-> core_clk_en);
endmodule

// File: tb/dbg_clock_freeze_tb.sv
module dbg_clock_freeze_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_stop = 1'b0;
    logic        step_req = 1'b0;
    logic        resume = 1'b0;
    logic [31:0] stop_at = '0;
    logic        stop_at_en = 1'b0;
    logic        core_clk_en;
    logic [31:0] cycle_cnt;
    logic        frozen;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_clock_freeze u_dut (
        .clk(clk), .rst_n(rst_n), .ext_stop(ext_stop), .step_req(step_req),
        .resume(resume), .stop_at(stop_at), .stop_at_en(stop_at_en),
        .core_clk_en(core_clk_en), .cycle_cnt(cycle_cnt), .frozen(frozen)
    );

    localparam int NV = 4;
    localparam logic [31:0] STOP_TAB [NV] = '{32'd0, 32'd1, 32'd7, 32'd23};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] sa, input logic sen);
        @(negedge clk);
        rst_n = 1'b0; stop_at = sa; stop_at_en = sen;
        ext_stop = 1'b0; step_req = 1'b0; resume = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0;
        // R1 reset state
        do_reset(32'd100, 1'b1);
        chk("R1 frozen", {31'd0, frozen}, 32'd0);
        chk("R1 cnt", cycle_cnt, 32'd0);
        chk("R1 en", {31'd0, core_clk_en}, 32'd1);

        // R2 table of stop values
        for (int v = 0; v < NV; v++) begin
            do_reset(STOP_TAB[v], 1'b1);
            cyc(40);
            chk("R2 frozen", {31'd0, frozen}, 32'd1);
            chk("R2 cnt", cycle_cnt, STOP_TAB[v]);
            chk("R2 en", {31'd0, core_clk_en}, 32'd0);
        end

        // R9 stop disabled
        do_reset(32'd3, 1'b0);
        cyc(10);
        chk("R9 cnt", cycle_cnt, 32'd10);
        chk("R9 frozen", {31'd0, frozen}, 32'd0);

        // R6 step in RUN ignored
        c0 = cycle_cnt;
        step_req = 1'b1;
        cyc(3);
        step_req = 1'b0;
        chk("R6 frozen", {31'd0, frozen}, 32'd0);
        chk("R6 cnt", cycle_cnt, c0 + 32'd3);

        // R4 external stop
        c0 = cycle_cnt;
        ext_stop = 1'b1;
        cyc(2);
        chk("R4 en", {31'd0, core_clk_en}, 32'd0);
        cyc(1);
        chk("R4 frozen", {31'd0, frozen}, 32'd1);
        chk("R4 cnt", cycle_cnt, c0 + 32'd2);
        // R3 hold while frozen
        cyc(5);
        chk("R3 hold", cycle_cnt, c0 + 32'd2);
        ext_stop = 1'b0;
        cyc(3);

        // R5 single step
        c0 = cycle_cnt;
        step_req = 1'b1;
        cyc(1);
        chk("R5 en", {31'd0, core_clk_en}, 32'd1);
        cyc(1);
        chk("R5 refrozen", {31'd0, frozen}, 32'd1);
        chk("R5 cnt", cycle_cnt, c0 + 32'd1);
        cyc(4);
        chk("R5 held", cycle_cnt, c0 + 32'd1);
        step_req = 1'b0;
        cyc(1);

        // R8 resume and step together
        c0 = cycle_cnt;
        resume = 1'b1; step_req = 1'b1;
        cyc(1);
        resume = 1'b0; step_req = 1'b0;
        chk("R8 en", {31'd0, core_clk_en}, 32'd1);
        cyc(3);
        chk("R8 running", {31'd0, frozen}, 32'd0);
        chk("R8 cnt", cycle_cnt, c0 + 32'd3);

        // R7 resume past a still-matching stop value
        do_reset(32'd4, 1'b1);
        cyc(10);
        chk("R7 stopped", cycle_cnt, 32'd4);
        resume = 1'b1;
        cyc(1);
        resume = 1'b0;
        cyc(1);
        chk("R7 cnt", cycle_cnt, 32'd5);
        chk("R7 frozen", {31'd0, frozen}, 32'd0);
        cyc(5);
        chk("R7 run", cycle_cnt, 32'd10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule